// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

When a transfer on a two-wire bus is cut short (a reset in the middle of a read, for example), a slave may be left partway through a byte, holding SDA low while it waits for clocks that never arrive. The bus then looks permanently occupied. This sequencer is started once by the host logic after reset, or when bus initialisation begins. It first allows any transfer still in flight a bounded time to complete. It then decides whether the bus is stuck. If so, it takes the SCL and SDA pins away from the I2C engine and clocks SCL by hand until the slave lets go of SDA, up to a fixed number of pulses. Afterwards it hands the pins back to the engine.

The block has a small set of named states. `ST_IDLE` waits for a start strobe. `ST_WAIT` watches the busy status until it clears or the wait limit runs out. `ST_LEAD_LOW` holds SCL low for one period. `ST_PULSE_HIGH` and `ST_PULSE_LOW` form one clock pulse. `ST_TAIL_HIGH` holds SCL high for one final period. `ST_FINISH` returns the pins and reports the outcome.

The transitions are as follows:
- start: `ST_IDLE` to `ST_WAIT`.
- clear: `ST_WAIT` to `ST_FINISH`, when the bus is free and SDA is high.
- stuck: `ST_WAIT` to `ST_LEAD_LOW`.
- pulse: `ST_LEAD_LOW` or `ST_PULSE_LOW` to `ST_PULSE_HIGH`.
- fall: `ST_PULSE_HIGH` to `ST_PULSE_LOW`.
- stop: `ST_LEAD_LOW` or `ST_PULSE_LOW` to `ST_TAIL_HIGH`, when SDA is high or the pulse limit has been reached.
- tail: `ST_TAIL_HIGH` to `ST_FINISH`.
- back: `ST_FINISH` to `ST_IDLE`.

One delay period is `HOLD_CYCLES` clock cycles. It is 1 ms on silicon and can be set short for simulation.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, pin_gpio_sel is 0, scl_drive is 1, done is 0 and fail is 0.
- R2: A start strobe in idle waits while bus_busy is 1, for at most WAIT_CYCLES cycles. If bus_busy is then 0 and sda_in is 1, the sequence finishes without taking the pins: pin_gpio_sel stays 0, done pulses and fail is 0.
- R3: If bus_busy is still 1 when the wait limit expires, or sda_in is 0 when the wait ends, recovery runs. pin_gpio_sel is 1 (the pins are driven as GPIO) from the first SCL low until the pins are returned.
- R4: Recovery first drives scl_drive to 0 for exactly HOLD_CYCLES cycles.
- R5: Each SCL pulse is scl_drive = 1 for HOLD_CYCLES cycles followed by scl_drive = 0 for HOLD_CYCLES cycles.
- R6: sda_in is sampled in the last cycle of every low phase. If it reads 1, no further pulse is issued.
- R7: No more than MAX_PULSES pulses are issued in one recovery, so scl_drive rises at most MAX_PULSES+1 times (pulses plus the tail).
- R8: Recovery ends with scl_drive = 1 for HOLD_CYCLES cycles. pin_gpio_sel then returns to 0 in the same cycle in which done is 1, and done is 1 for exactly one cycle.
- R9: fail becomes 1 only when sda_in still reads 0 at the check after the MAX_PULSES-th pulse. fail stays at its value until the next accepted start, which clears it.
- R10: A start strobe that arrives while a sequence is running has no effect on pulse count, timing or the number of done pulses.
- R11: Whenever pin_gpio_sel is 0, scl_drive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to check and recover the bus |
| bus_busy | input | 1 | Busy status from the I2C engine |
| sda_in | input | 1 | Synchronised level of the SDA pin |
| scl_drive | output | 1 | SCL level driven while pins are in GPIO mode (1 = released) |
| pin_gpio_sel | output | 1 | 1 = pins owned by the sequencer, 0 = owned by the I2C engine |
| done | output | 1 | One-cycle pulse when a sequence has ended |
| fail | output | 1 | SDA was still low after the last permitted pulse |

## Verification
The assertions check on every cycle that SCL stays released whenever the engine owns the pins. They also check that pin ownership begins with SCL low and always comes back together with a single-cycle done. Every low phase must last exactly one period, the number of SCL rises in a session must stay within the limit, and fail may only rise while the pins are held. The bench scenarios are needed to show behaviour that depends on context: whether recovery runs at all, given the different busy and SDA histories; how many pulses a slave that releases after a given count actually receives; fail when SDA is released exactly at the limit and when it is never released; fail persisting after the run and clearing on the next start; and a start strobe during a run being ignored.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT       = 3'd1,
        ST_LEAD_LOW   = 3'd2,
        ST_PULSE_HIGH = 3'd3,
        ST_PULSE_LOW  = 3'd4,
        ST_TAIL_HIGH  = 3'd5,
        ST_FINISH     = 3'd6
    } unstick_state_e;

    function automatic logic is_timed(unstick_state_e s);
        return (s == ST_LEAD_LOW) || (s == ST_PULSE_HIGH) ||
               (s == ST_PULSE_LOW) || (s == ST_TAIL_HIGH);
    endfunction

endpackage

// File: rtl/unstick_period_timer.sv
module unstick_period_timer #(
    parameter int unsigned LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/unstick_pulse_counter.sv
module unstick_pulse_counter #(
    parameter int unsigned MAX_PULSES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic at_max
);
    localparam int unsigned PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] TOP = PW'(MAX_PULSES);

    logic [PW-1:0] n_q;

    assign at_max = (n_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0;
        end else if (clear) begin
            n_q <= '0;
        end else if (incr && !at_max) begin
            n_q <= n_q + PW'(1);
        end
    end
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
    import i2c_unstick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bus_busy,
    input  logic sda_in,
    input  logic hold_tick,
    input  logic wait_tick,
    input  logic at_max,
    output logic hold_run,
    output logic wait_run,
    output logic cnt_clear,
    output logic cnt_incr,
    output logic scl_drive,
    output logic pin_gpio_sel,
    output logic done,
    output logic fail
);
    unstick_state_e state_q, state_d;
    logic fail_q;
    logic low_end;
    logic stop_now;

    assign low_end  = hold_tick && ((state_q == ST_LEAD_LOW) || (state_q == ST_PULSE_LOW));
    assign stop_now = sda_in || at_max;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_WAIT;
            ST_WAIT:       if (!bus_busy || wait_tick)
                               state_d = (bus_busy || !sda_in) ? ST_LEAD_LOW : ST_FINISH;
            ST_LEAD_LOW,
            ST_PULSE_LOW:  if (hold_tick)
                               state_d = stop_now ? ST_TAIL_HIGH : ST_PULSE_HIGH;
            ST_PULSE_HIGH: if (hold_tick) state_d = ST_PULSE_LOW;
            ST_TAIL_HIGH:  if (hold_tick) state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                fail_q <= 1'b0;
            end else if (low_end && at_max && !sda_in) begin
                fail_q <= 1'b1;
            end
        end
    end

    always_comb begin
        hold_run     = is_timed(state_q);
        wait_run     = (state_q == ST_WAIT);
        cnt_clear    = (state_q == ST_IDLE);
        cnt_incr     = (state_q == ST_PULSE_HIGH) && hold_tick;
        pin_gpio_sel = is_timed(state_q);
        scl_drive    = !((state_q == ST_LEAD_LOW) || (state_q == ST_PULSE_LOW));
        done         = (state_q == ST_FINISH);
        fail         = fail_q;
    end
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq #(
    parameter int unsigned HOLD_CYCLES = 100000,
    parameter int unsigned WAIT_CYCLES = 100000000,
    parameter int unsigned MAX_PULSES  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bus_busy,
    input  logic sda_in,
    output logic scl_drive,
    output logic pin_gpio_sel,
    output logic done,
    output logic fail
);
    logic hold_run, hold_tick;
    logic wait_run, wait_tick;
    logic cnt_clear, cnt_incr, at_max;

    unstick_period_timer #(.LIMIT(HOLD_CYCLES)) u_hold_timer (
        .clk(clk), .rst_n(rst_n), .run(hold_run), .tick(hold_tick)
    );

    unstick_period_timer #(.LIMIT(WAIT_CYCLES)) u_wait_timer (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .tick(wait_tick)
    );

    unstick_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .incr(cnt_incr), .at_max(at_max)
    );

    unstick_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_busy(bus_busy), .sda_in(sda_in),
        .hold_tick(hold_tick), .wait_tick(wait_tick), .at_max(at_max),
        .hold_run(hold_run), .wait_run(wait_run), .cnt_clear(cnt_clear), .cnt_incr(cnt_incr),
        .scl_drive(scl_drive), .pin_gpio_sel(pin_gpio_sel), .done(done), .fail(fail)
    );
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
    parameter int unsigned HOLD_CYCLES = 100000,
    parameter int unsigned MAX_PULSES  = 10
) (
    input logic clk,
    input logic rst_n,
    input logic scl_drive,
    input logic pin_gpio_sel,
    input logic done,
    input logic fail
);
    logic [31:0] low_run_q;
    logic [31:0] rises_q;
    logic        scl_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            rises_q    <= '0;
            scl_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_drive;
            low_run_q  <= (pin_gpio_sel && !scl_drive) ? low_run_q + 32'd1 : 32'd0;
            if (!pin_gpio_sel) rises_q <= '0;
            else if (scl_drive && !scl_prev_q) rises_q <= rises_q + 32'd1;
        end
    end

    a_r11_scl_released: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_gpio_sel |-> scl_drive);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_return_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_gpio_sel) |-> done);
    a_r4_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_gpio_sel) |-> !scl_drive);
    a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_drive) && pin_gpio_sel) |-> (low_run_q == HOLD_CYCLES));
    a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= MAX_PULSES + 1);
    a_r9_fail_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> pin_gpio_sel);
endmodule

bind i2c_unstick_seq i2c_unstick_chk #(
    .HOLD_CYCLES(HOLD_CYCLES), .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_drive(scl_drive),
    .pin_gpio_sel(pin_gpio_sel), .done(done), .fail(fail)
);

// File: tb/sim_i2c_unstick_seq.sv
module sim_i2c_unstick_seq;
    localparam int HOLD = 4;
    localparam int WAITC = 16;
    localparam int MAXP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bus_busy = 1'b0;
    logic stuck = 1'b0;
    int   release_at = 0;
    logic scl_drive, pin_gpio_sel, done, fail;
    logic sda_in;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int  rises;
        int  low_cyc;
        int  high_cyc;
        logic fail_v;
        logic took_pins;
    } exp_t;
    exp_t exp_q[$];

    int scl_rises = 0;
    int low_cyc = 0;
    int high_cyc = 0;
    logic took = 1'b0;
    int dones = 0;

    always #2 clk = ~clk;

    i2c_unstick_seq #(.HOLD_CYCLES(HOLD), .WAIT_CYCLES(WAITC), .MAX_PULSES(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_busy(bus_busy), .sda_in(sda_in),
        .scl_drive(scl_drive), .pin_gpio_sel(pin_gpio_sel), .done(done), .fail(fail)
    );

    // slave model: holds SDA low until it has seen release_at SCL rises
    assign sda_in = !(stuck && (scl_rises < release_at));

    always @(posedge scl_drive) if (pin_gpio_sel) scl_rises = scl_rises + 1;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: accumulate per-run measurements, compare on done
    always @(negedge clk) begin
        if (rst_n) begin
            if (pin_gpio_sel) begin
                took = 1'b1;
                if (scl_drive) high_cyc++; else low_cyc++;
            end
            if (done) begin
                chk(!pin_gpio_sel && scl_drive, "R8 pins returned at done", pin_gpio_sel, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(took == e.took_pins, "R2/R3 pin takeover", took, e.took_pins);
                    chk(scl_rises == e.rises, "R6/R7 SCL rises", scl_rises, e.rises);
                    chk(low_cyc == e.low_cyc, "R4/R5 low cycles", low_cyc, e.low_cyc);
                    chk(high_cyc == e.high_cyc, "R5/R8 high cycles", high_cyc, e.high_cyc);
                    chk(fail == e.fail_v, "R9 fail flag", fail, e.fail_v);
                end
                scl_rises = 0; low_cyc = 0; high_cyc = 0; took = 1'b0;
                dones++;
            end
        end
    end

    // driver: busy_mode 0 free, 1 stuck busy, 2 busy clears after 5 cycles
    task automatic run_case(input int busy_mode, input logic stk, input int rel, input logic extra_start);
        exp_t e;
        int pulses;
        int target;
        logic rec;
        rec = (busy_mode == 1) || stk;
        pulses = 0;
        if (rec && stk) pulses = (rel < MAXP) ? rel : MAXP;
        e.took_pins = rec;
        e.rises     = rec ? pulses + 1 : 0;
        e.low_cyc   = rec ? (pulses + 1) * HOLD : 0;
        e.high_cyc  = rec ? (pulses + 1) * HOLD : 0;
        e.fail_v    = rec && stk && (rel > MAXP);
        exp_q.push_back(e);
        target = dones + 1;
        @(negedge clk);
        stuck = stk; release_at = rel;
        bus_busy = (busy_mode != 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(fail == 1'b0, "R9 fail cleared by start", fail, 0);
        if (busy_mode == 2) begin
            repeat (5) @(negedge clk);
            bus_busy = 1'b0;
        end
        if (extra_start) begin
            wait (pin_gpio_sel);
            repeat (6) @(negedge clk);
            start = 1'b1;   // R10: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        wait (dones == target);
        @(negedge clk);
        bus_busy = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pin_gpio_sel == 1'b0, "R1 gpio_sel reset", pin_gpio_sel, 0);
        chk(scl_drive == 1'b1, "R1/R11 scl reset", scl_drive, 1);
        chk(done == 1'b0, "R1 done reset", done, 0);
        chk(fail == 1'b0, "R1 fail reset", fail, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_case(0, 1'b0, 0, 1'b0);   // R2 clean bus
        run_case(2, 1'b0, 0, 1'b0);   // R2 busy clears in wait
        run_case(1, 1'b0, 0, 1'b0);   // R3 busy stays: zero pulses
        run_case(0, 1'b1, 3, 1'b0);   // R6 releases after 3
        run_case(0, 1'b1, 99, 1'b0);  // R7 R9 never releases
        repeat (20) @(negedge clk);
        chk(fail == 1'b1, "R9 fail held after run", fail, 1);
        run_case(0, 1'b1, MAXP, 1'b0); // R9 release exactly at limit
        run_case(2, 1'b1, 1, 1'b0);   // R3 sda low after busy clears
        run_case(0, 1'b1, 3, 1'b1);   // R10 extra start ignored
        repeat (60) @(negedge clk);
        chk(pin_gpio_sel == 1'b0, "R10 no second run", pin_gpio_sel, 0);
        chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule